// File: doc/BRIEF.md
# AHB-Lite Asynchronous Parallel Memory Controller

This block is an AHB-Lite slave that connects the internal bus to clockless parallel memories, such as asynchronous SRAM or NOR flash, over a shared narrow data bus. It takes one single transfer at a time. It splits each byte, half-word or word transfer into one or more external cycles, each as wide as the external bus (8 or 16 bits). It generates active-low chip-select, output-enable, write-enable and per-lane byte-enable strobes by counting system clocks.

While the external cycles run, the bus is held with HREADYOUT low. Each external cycle has one address set-up clock followed by a programmable number of access clocks. Read bytes are placed into their own HRDATA lanes. Write bytes are taken from their own HWDATA lanes. Byte enables work as per-device write strobes when byte-wide parts share the bus. Address bit 24 picks one of two banks.

Top module: `ahb_async_mem_ctrl`

## Requirements
- R1: During and right after reset, HREADYOUT is 1, both chip selects are high (2'b11), output enable and write enable are high, and the data bus is not driven.
- R2: A transfer with HADDR in 0x7000_0000..0x77FF_FFFF accesses the memory. A transfer outside that window finishes with zero wait states, asserts no chip select, and changes no memory content.
- R3: HADDR[24]=0 selects mem_cs_n[0] and HADDR[24]=1 selects mem_cs_n[1]. No more than one chip select is low at any time.
- R4: The external address is {HADDR[23:2], word index}, where the word index is the position of the external word inside the 32-bit lane group (1 bit for a 16-bit bus, 2 bits for an 8-bit bus). mem_be_n bit b is low when byte lane b of the current word is part of the transfer.
- R5: The bytes moved are HADDR[1:0] up to HADDR[1:0]+size-1 (HSIZE 0=byte, 1=half, 2=word), clipped at lane 3. One external cycle is issued for each external word those bytes touch, in ascending order. A misaligned half-word therefore takes two cycles on a 16-bit bus.
- R6: Each external cycle lasts 1+ACC_CYC clocks. HREADYOUT stays low for exactly that many clocks times the number of external cycles. This gives 3 wait states for a single cycle with ACC_CYC=2.
- R7: Read data is sampled on the last access clock of each external cycle and placed in the matching HRDATA byte lanes. Lanes outside the transfer read as zero. HRESP is always OKAY (0).
- R8: Write data for the current word comes from the matching HWDATA lanes. It is driven only while mem_we_n is low. Memory bytes outside the transfer keep their old value.
- R9: mem_oe_n low and mem_dq_oe high never occur together. A clock in which mem_oe_n was low is never directly followed by one in which the bus is driven.
- R10: A cycle with HSEL low, or with HTRANS IDLE or BUSY, starts no transfer. HREADYOUT stays high and no strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | System clock |
| hresetn | input | 1 | Active-low asynchronous reset |
| hsel | input | 1 | Slave select |
| haddr | input | 32 | Transfer address |
| htrans | input | 2 | Transfer type (bit 1 set = NONSEQ/SEQ) |
| hwrite | input | 1 | 1 = write |
| hsize | input | 3 | Transfer size |
| hwdata | input | 32 | Write data, held stable through the data phase |
| hready | input | 1 | Bus-wide ready |
| hreadyout | output | 1 | Slave ready |
| hrdata | output | 32 | Read data |
| hresp | output | 1 | Response, always OKAY |
| mem_addr | output | CS_BIT-log2(DATA_W/8) | External word address |
| mem_cs_n | output | 2 | Active-low bank selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_be_n | output | DATA_W/8 | Active-low byte-lane enables |
| mem_dq_out | output | DATA_W | External data out |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | External data in |

## Verification
The bench builds the block with a 16-bit external bus and two access clocks, which is the baseline three-wait-state case. The 16-bit width makes a word transfer need two external cycles. It also lets a half-word at an odd address straddle two external words, so the lane splitting and the misaligned-address path are exercised with real multi-cycle sequences. With two access clocks, each strobe is held low for more than one clock. This exposes any change of address during the strobe, and any overlap between the output enable and the data drive when a read is followed directly by a write.

// File: rtl/emc_pkg.sv
package emc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACC,
        ST_DONE
    } emc_state_e;
endpackage

// File: rtl/emc_lane_plan.sv
module emc_lane_plan #(
    parameter int LS    = 1,
    parameter int SEG_W = 1
) (
    input  logic [1:0]       addr_lo,
    input  logic [2:0]       size,
    output logic [3:0]       mask,
    output logic [SEG_W-1:0] first_seg,
    output logic [SEG_W-1:0] last_seg
);
    logic [3:0] full;
    logic [3:0] m;
    logic [1:0] hi;

    always_comb begin
        case (size)
            3'd0:    full = 4'b0001;
            3'd1:    full = 4'b0011;
            default: full = 4'b1111;
        endcase
        m  = full << addr_lo;
        hi = 2'd0;
        for (int i = 0; i < 4; i++) begin
            if (m[i]) hi = 2'(i);
        end
        mask      = m;
        first_seg = SEG_W'(addr_lo >> LS);
        last_seg  = SEG_W'(hi >> LS);
    end
endmodule

// File: rtl/emc_strobe_gen.sv
module emc_strobe_gen
    import emc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTES  = 2,
    parameter int SEG_W  = 1,
    parameter int AH_W   = 22,
    parameter int EXT_AW = 23
) (
    input  emc_state_e        st,
    input  logic              wr,
    input  logic              cs_sel,
    input  logic [3:0]        mask,
    input  logic [SEG_W-1:0]  seg,
    input  logic [AH_W-1:0]   addr_hi,
    input  logic [31:0]       hwdata,
    output logic [EXT_AW-1:0] mem_addr,
    output logic [1:0]        mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [BYTES-1:0]  mem_be_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe
);
    logic             active;
    logic             access;
    logic [BYTES-1:0] lanes;

    always_comb begin
        active     = (st == ST_ADDR) || (st == ST_ACC);
        access     = (st == ST_ACC);
        lanes      = mask[int'(seg)*BYTES +: BYTES];
        mem_addr   = {addr_hi, seg};
        mem_cs_n   = active ? (cs_sel ? 2'b01 : 2'b10) : 2'b11;
        mem_be_n   = active ? ~lanes : '1;
        mem_oe_n   = !(access && !wr);
        mem_we_n   = !(access && wr);
        mem_dq_oe  = access && wr;
        mem_dq_out = hwdata[int'(seg)*DATA_W +: DATA_W];
    end
endmodule

// File: rtl/ahb_async_mem_ctrl.sv
module ahb_async_mem_ctrl
    import emc_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ACC_CYC = 2,
    parameter int CS_BIT  = 24,
    parameter logic [31:0] WIN_BASE = 32'h7000_0000
) (
    input  logic                                  hclk,
    input  logic                                  hresetn,
    input  logic                                  hsel,
    input  logic [31:0]                           haddr,
    input  logic [1:0]                            htrans,
    input  logic                                  hwrite,
    input  logic [2:0]                            hsize,
    input  logic [31:0]                           hwdata,
    input  logic                                  hready,
    output logic                                  hreadyout,
    output logic [31:0]                           hrdata,
    output logic                                  hresp,
    output logic [CS_BIT-$clog2(DATA_W/8)-1:0]    mem_addr,
    output logic [1:0]                            mem_cs_n,
    output logic                                  mem_oe_n,
    output logic                                  mem_we_n,
    output logic [DATA_W/8-1:0]                   mem_be_n,
    output logic [DATA_W-1:0]                     mem_dq_out,
    output logic                                  mem_dq_oe,
    input  logic [DATA_W-1:0]                     mem_dq_in
);
    localparam int BYTES   = DATA_W / 8;
    localparam int LS      = $clog2(BYTES);
    localparam int SEG_W   = 2 - LS;
    localparam int EXT_AW  = CS_BIT - LS;
    localparam int AH_W    = CS_BIT - 2;
    localparam int WIN_LSB = CS_BIT + 3;
    localparam int CNT_W   = $clog2(ACC_CYC + 1);

    typedef struct packed {
        emc_state_e       st;
        logic [AH_W-1:0]  ahi;
        logic             cs;
        logic             wr;
        logic [3:0]       mask;
        logic [SEG_W-1:0] seg;
        logic [SEG_W-1:0] last;
        logic [CNT_W-1:0] cnt;
        logic [31:0]      rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [3:0]       plan_mask;
    logic [SEG_W-1:0] plan_first;
    logic [SEG_W-1:0] plan_last;
    logic             accept;
    logic             in_win;
    logic             unused_bits;

    assign unused_bits = &{1'b0, htrans[0], haddr[WIN_LSB-1:CS_BIT+1]};

    emc_lane_plan #(
        .LS    (LS),
        .SEG_W (SEG_W)
    ) i_plan (
        .addr_lo   (haddr[1:0]),
        .size      (hsize),
        .mask      (plan_mask),
        .first_seg (plan_first),
        .last_seg  (plan_last)
    );

    always_comb begin
        accept = ((r_q.st == ST_IDLE) || (r_q.st == ST_DONE))
                 && hsel && hready && htrans[1];
        in_win = (haddr[31:WIN_LSB] == WIN_BASE[31:WIN_LSB]);
        r_d    = r_q;
        case (r_q.st)
            ST_IDLE, ST_DONE: begin
                if (accept) begin
                    r_d.rdata = '0;
                    if (in_win) begin
                        r_d.st   = ST_ADDR;
                        r_d.ahi  = haddr[CS_BIT-1:2];
                        r_d.cs   = haddr[CS_BIT];
                        r_d.wr   = hwrite;
                        r_d.mask = plan_mask;
                        r_d.seg  = plan_first;
                        r_d.last = plan_last;
                    end else begin
                        r_d.st = ST_DONE;
                    end
                end else begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_ADDR: begin
                r_d.st  = ST_ACC;
                r_d.cnt = CNT_W'(ACC_CYC - 1);
            end
            ST_ACC: begin
                if (r_q.cnt == '0) begin
                    if (!r_q.wr) begin
                        for (int b = 0; b < BYTES; b++) begin
                            if (r_q.mask[int'(r_q.seg)*BYTES + b]) begin
                                r_d.rdata[(int'(r_q.seg)*BYTES + b)*8 +: 8] =
                                    mem_dq_in[b*8 +: 8];
                            end
                        end
                    end
                    if (r_q.seg == r_q.last) begin
                        r_d.st = ST_DONE;
                    end else begin
                        r_d.seg = r_q.seg + SEG_W'(1);
                        r_d.st  = ST_ADDR;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hreadyout = (r_q.st == ST_IDLE) || (r_q.st == ST_DONE);
    assign hrdata    = r_q.rdata;
    assign hresp     = 1'b0;

    emc_strobe_gen #(
        .DATA_W (DATA_W),
        .BYTES  (BYTES),
        .SEG_W  (SEG_W),
        .AH_W   (AH_W),
        .EXT_AW (EXT_AW)
    ) i_strobe (
        .st         (r_q.st),
        .wr         (r_q.wr),
        .cs_sel     (r_q.cs),
        .mask       (r_q.mask),
        .seg        (r_q.seg),
        .addr_hi    (r_q.ahi),
        .hwdata     (hwdata),
        .mem_addr   (mem_addr),
        .mem_cs_n   (mem_cs_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_be_n   (mem_be_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe)
    );
endmodule

// File: rtl/emc_checker.sv
module emc_checker (
    input logic        hclk,
    input logic        hresetn,
    input logic        hsel,
    input logic        hready,
    input logic        hreadyout,
    input logic [1:0]  htrans,
    input logic [31:0] haddr,
    input logic [1:0]  mem_cs_n,
    input logic        mem_oe_n,
    input logic        mem_we_n,
    input logic        mem_dq_oe,
    input logic        addr_par
);
    // R9
    oe_drive_excl_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        !(!mem_oe_n && mem_dq_oe));

    // R9
    turnaround_gap_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        !$past(mem_oe_n) |-> !mem_dq_oe);

    // R8
    drive_with_we_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        mem_dq_oe |-> !mem_we_n);

    // R3
    single_bank_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        $onehot0(~mem_cs_n));

    // R3
    strobe_needs_cs_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        (!mem_oe_n || !mem_we_n) |-> (mem_cs_n != 2'b11));

    // R4
    addr_hold_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        ((!mem_oe_n && $past(!mem_oe_n)) || (!mem_we_n && $past(!mem_we_n)))
        |-> $stable(addr_par));

    // R6
    wait_starts_access_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        $fell(hreadyout) |-> (mem_cs_n != 2'b11));

    // R2
    out_of_window_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        (hsel && hready && hreadyout && htrans[1] && (haddr[31:27] != 5'b01110))
        |=> (hreadyout && (mem_cs_n == 2'b11)));

    // R10
    idle_ignored_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        (hreadyout && !(hsel && hready && htrans[1]))
        |=> (hreadyout && (mem_cs_n == 2'b11)));
endmodule

bind ahb_async_mem_ctrl emc_checker i_emc_checker (
    .hclk      (hclk),
    .hresetn   (hresetn),
    .hsel      (hsel),
    .hready    (hready),
    .hreadyout (hreadyout),
    .htrans    (htrans),
    .haddr     (haddr),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe),
    .addr_par  (^mem_addr)
);

// File: tb/test_ahb_async_mem_ctrl.sv
module test_ahb_async_mem_ctrl;
    localparam int DATA_W = 16;
    localparam int ACC_CYC = 2;
    localparam int EXT_AW = 23;
    localparam int NVEC = 12;

    logic              clk = 1'b0;
    logic              hresetn = 1'b0;
    logic              hsel = 1'b0;
    logic [31:0]       haddr = '0;
    logic [1:0]        htrans = '0;
    logic              hwrite = 1'b0;
    logic [2:0]        hsize = '0;
    logic [31:0]       hwdata = '0;
    logic              hready;
    logic              hreadyout;
    logic [31:0]       hrdata;
    logic              hresp;
    logic [EXT_AW-1:0] mem_addr;
    logic [1:0]        mem_cs_n;
    logic              mem_oe_n;
    logic              mem_we_n;
    logic [1:0]        mem_be_n;
    logic [15:0]       mem_dq_out;
    logic              mem_dq_oe;
    logic [15:0]       mem_dq_in;

    logic [15:0] mem0 [256];
    logic [15:0] mem1 [256];

    int checks = 0;
    int errors = 0;
    int overlap_err = 0;
    int drive_err = 0;
    int gap_err = 0;
    logic prev_oe_low = 1'b0;

    always #10 clk = ~clk;
    assign hready = hreadyout;

    ahb_async_mem_ctrl #(
        .DATA_W  (DATA_W),
        .ACC_CYC (ACC_CYC)
    ) i_ahb_async_mem_ctrl (
        .hclk       (clk),
        .hresetn    (hresetn),
        .hsel       (hsel),
        .haddr      (haddr),
        .htrans     (htrans),
        .hwrite     (hwrite),
        .hsize      (hsize),
        .hwdata     (hwdata),
        .hready     (hready),
        .hreadyout  (hreadyout),
        .hrdata     (hrdata),
        .hresp      (hresp),
        .mem_addr   (mem_addr),
        .mem_cs_n   (mem_cs_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_be_n   (mem_be_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (mem_dq_in)
    );

    // asynchronous memory model: combinational read, write sampled mid-cycle
    always_comb begin
        if (mem_oe_n) mem_dq_in = 16'h0;
        else if (!mem_cs_n[0]) mem_dq_in = mem0[mem_addr[7:0]];
        else if (!mem_cs_n[1]) mem_dq_in = mem1[mem_addr[7:0]];
        else mem_dq_in = 16'h0;
    end

    always @(negedge clk) begin
        if (!mem_we_n && mem_dq_oe) begin
            for (int b = 0; b < 2; b++) begin
                if (!mem_be_n[b]) begin
                    if (!mem_cs_n[0]) mem0[mem_addr[7:0]][b*8 +: 8] <= mem_dq_out[b*8 +: 8];
                    if (!mem_cs_n[1]) mem1[mem_addr[7:0]][b*8 +: 8] <= mem_dq_out[b*8 +: 8];
                end
            end
        end
        if (!mem_oe_n && mem_dq_oe) overlap_err++;
        if (mem_dq_oe && mem_we_n) drive_err++;
        if (mem_dq_oe && prev_oe_low) gap_err++;
        prev_oe_low = !mem_oe_n;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge where hreadyout is high again
    task automatic xfer(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] d, output logic [31:0] rd,
                        output int waits, output int c0, output int c1,
                        output logic [7:0] ea);
        hsel = 1'b1; haddr = a; htrans = 2'b10; hwrite = wr; hsize = {1'b0, sz};
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00; hwdata = d;
        waits = 0; c0 = 0; c1 = 0; ea = 8'hFF;
        while (!hreadyout && waits < 100) begin
            waits++;
            if (!mem_cs_n[0]) c0++;
            if (!mem_cs_n[1]) c1++;
            if (mem_cs_n != 2'b11) ea = mem_addr[7:0];
            @(negedge clk);
        end
        rd = hrdata;
    endtask

    // {wr, size, bank, addr, data/expected, waits, last external address}
    localparam logic [79:0] VEC [NVEC] = '{
        {1'b1, 2'd2, 1'b0, 32'h7000_0000, 32'h1122_3344, 4'd6, 8'd1},
        {1'b0, 2'd2, 1'b0, 32'h7000_0000, 32'h1122_3344, 4'd6, 8'd1},
        {1'b1, 2'd0, 1'b0, 32'h7000_0005, 32'h0000_AA00, 4'd3, 8'd2},
        {1'b0, 2'd2, 1'b0, 32'h7000_0004, 32'h0000_AA00, 4'd6, 8'd3},
        {1'b1, 2'd1, 1'b1, 32'h7100_0002, 32'hBEEF_0000, 4'd3, 8'd1},
        {1'b0, 2'd1, 1'b1, 32'h7100_0002, 32'hBEEF_0000, 4'd3, 8'd1},
        {1'b0, 2'd1, 1'b0, 32'h7000_0002, 32'h1122_0000, 4'd3, 8'd1},
        {1'b0, 2'd1, 1'b0, 32'h7000_0001, 32'h0022_3300, 4'd6, 8'd1},
        {1'b1, 2'd1, 1'b0, 32'h7000_0009, 32'h00CD_AB00, 4'd6, 8'd5},
        {1'b0, 2'd2, 1'b0, 32'h7000_0008, 32'h00CD_AB00, 4'd6, 8'd5},
        {1'b1, 2'd2, 1'b1, 32'h7100_0004, 32'hCAFE_F00D, 4'd6, 8'd3},
        {1'b0, 2'd0, 1'b1, 32'h7100_0007, 32'hCA00_0000, 4'd3, 8'd3}
    };

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int waits, c0, c1;
        logic [7:0] ea;

        for (int i = 0; i < 256; i++) begin
            mem0[i] = 16'h0;
            mem1[i] = 16'h0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check(hreadyout && mem_cs_n == 2'b11 && mem_oe_n && mem_we_n && !mem_dq_oe,
              "R1 reset outputs", {27'd0, hreadyout, mem_cs_n, mem_oe_n, mem_dq_oe},
              {27'd0, 1'b1, 2'b11, 1'b1, 1'b0});
        hresetn = 1'b1;
        @(negedge clk);
        check(hreadyout && mem_cs_n == 2'b11, "R1 after release",
              {30'd0, mem_cs_n}, 32'd3);

        // vector walk, back to back
        for (int i = 0; i < NVEC; i++) begin
            logic [79:0] v;
            v = VEC[i];
            xfer(v[79], v[78:77], v[75:44], v[43:12], rd, waits, c0, c1, ea);
            check(waits == int'(v[11:8]), $sformatf("R5 R6 wait states vec %0d", i),
                  waits, {28'd0, v[11:8]});
            check(ea == v[7:0], $sformatf("R4 external address vec %0d", i),
                  {24'd0, ea}, {24'd0, v[7:0]});
            check(v[76] ? (c1 == waits && c0 == 0) : (c0 == waits && c1 == 0),
                  $sformatf("R3 bank select vec %0d", i), {c1[15:0], c0[15:0]},
                  {31'd0, v[76]});
            if (!v[79]) begin
                check(rd == v[43:12] && hresp == 1'b0,
                      $sformatf("R7 R8 read data vec %0d", i), rd, v[43:12]);
            end
        end

        // R2 out-of-window write: no wait, no strobe, no memory change
        xfer(1'b1, 2'd2, 32'h6000_0000, 32'hDEAD_BEEF, rd, waits, c0, c1, ea);
        check(waits == 0 && c0 == 0 && c1 == 0, "R2 outside window",
              waits, 32'd0);
        xfer(1'b0, 2'd2, 32'h7000_0000, 32'h0, rd, waits, c0, c1, ea);
        check(rd == 32'h1122_3344, "R2 memory untouched", rd, 32'h1122_3344);

        // R10 idle transfer ignored
        @(negedge clk);
        hsel = 1'b1; haddr = 32'h7000_0000; htrans = 2'b00; hwrite = 1'b1;
        @(negedge clk);
        check(hreadyout && mem_cs_n == 2'b11, "R10 idle htrans",
              {30'd0, mem_cs_n}, 32'd3);
        htrans = 2'b01;
        @(negedge clk);
        check(hreadyout && mem_cs_n == 2'b11, "R10 busy htrans",
              {30'd0, mem_cs_n}, 32'd3);
        hsel = 1'b0; htrans = 2'b10;
        @(negedge clk);
        check(hreadyout && mem_cs_n == 2'b11, "R10 hsel low",
              {30'd0, mem_cs_n}, 32'd3);
        htrans = 2'b00;
        @(negedge clk);
        xfer(1'b0, 2'd2, 32'h7000_0000, 32'h0, rd, waits, c0, c1, ea);
        check(rd == 32'h1122_3344, "R10 memory untouched", rd, 32'h1122_3344);

        // R9 R8 bus-protocol monitors
        check(overlap_err == 0, "R9 oe/drive overlap", overlap_err, 32'd0);
        check(gap_err == 0, "R9 turnaround gap", gap_err, 32'd0);
        check(drive_err == 0, "R8 drive without we", drive_err, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule